// File: doc/BRIEF.md
# Display Interrupt Status Controller

This block gathers the event flags of a display controller that runs one primary and up to six auxiliary frame DMA channels. Event pulses from the DMA engine and from the panel enable logic set sticky flags in two status registers. Mask bits in two control registers decide which flags reach a single level-sensitive interrupt line. Software clears a flag by writing a one to its bit.

When an event that is allowed to interrupt arrives while the line is low, the block captures the frame ID of the channel that raised it. This tells the handler which frame caused the interrupt. If the line is already high when such an event arrives, the ID register is left alone and a sticky "more events pending" flag is set instead. A bus error also records the number of the failing channel, and that field is cleared together with the error flag.

The register port is a simple one-cycle write strobe with a combinational read mux. Pixel fetch and panel timing are handled elsewhere.

Top module: `disp_irq_ctrl`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: `irq` is high exactly when at least one of the following flag/mask pairs has its flag set and its mask bit clear:
  - FLAGA bits 0, 1, 4, 6, 7, 8, 9, 11 and 12 with MASKA bits 3, 4, 5, 21, 11, 6, 20, 23 and 24 respectively.
  - FLAGA bit 5 with MASKB bit 24.
  - Any FLAGB bit whose MASKB bit at the same position is clear.
  - FLAGA bits 2, 3 and 10 never drive `irq`.
- R3: A start-of-frame, end-of-frame or branch pulse is visible in the status one clock later, whether or not it is masked.
  - For channel 0 these pulses set FLAGA bits 1, 8 and 9.
  - For channel c in 1..6 they set FLAGB bits c-1, c+7 and c+15.
  - The masks in MASKB use the same positions.
- R4: An unmasked frame or branch event that arrives while `irq` is low loads EVID with that channel's frame ID one clock later. A masked event sets its flag only: it neither loads EVID nor sets FLAGA bit 10.
- R5: An unmasked frame, branch or bus-error event that arrives while `irq` is high sets FLAGA bit 10 and leaves EVID unchanged.
- R6: When several unmasked events arrive in one cycle while `irq` is low, the lowest channel number loads EVID and FLAGA bit 10 is set.
- R7: A bus-error pulse is never masked. It sets FLAGA bit 2, writes the 3-bit channel number into FLAGA bits 30:28, and follows the EVID/bit-10 rule of R4 to R6.
- R8: A write to FLAGA clears the flags whose bits are set in wdata[11:0]. Bits 30:28 are cleared only when wdata[2] is set. Bit 12 cannot be cleared by a write.
- R9: A write to FLAGB clears only the bits selected by 0x3E3F3F. Bit 16 therefore stays set.
- R10: A write to MASKA that takes bit 0 from 1 to 0 sets FLAGA bit 7 (quick disable).
- R11: MASKA keeps only bits 26:0 and MASKB keeps only bits under 0x3F3F3F3F. Writes to EVID and to unused addresses are ignored.
  - Register addresses: 0 MASKA, 1 MASKB, 2 FLAGA, 3 FLAGB, 4 EVID.
- R12: If an event sets a flag in the same cycle that a write clears it, the flag ends up set.
- R13: Seven other event pulses set FLAGA bits:
  - `ev_last` sets bit 0 and `ev_bias` sets bit 3.
  - `ev_urun0` sets bit 4, `ev_urun1` sets bit 5 and `ev_ourun` sets bit 6.
  - `ev_rdst` sets bit 11 and `ev_cmd` sets bit 12.
  - `ev_rdst` with MASKA bit 23 clear, arriving while `irq` is high, also sets bit 10.
  - None of these seven ever loads EVID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| ev_sof | input | NCH | Start-of-frame pulse per channel |
| ev_eof | input | NCH | End-of-frame pulse per channel |
| ev_brn | input | NCH | Branch-taken pulse per channel |
| ev_ber | input | 1 | Bus-error pulse |
| ber_chan | input | 3 | Channel of the bus error |
| ev_last | input | 1 | Last frame done pulse |
| ev_bias | input | 1 | Bias count pulse |
| ev_urun0 | input | 1 | Input underrun 0 pulse |
| ev_urun1 | input | 1 | Input underrun 1 pulse |
| ev_ourun | input | 1 | Output underrun pulse |
| ev_rdst | input | 1 | Read status pulse |
| ev_cmd | input | 1 | Command done pulse |
| frame_id | input | NCH*ID_W | Current frame ID of each channel |
| irq | output | 1 | Level interrupt |

## Verification
The hardest case to reach is an event that arrives while the line is already high. The line must first be raised by an earlier unmasked event and kept high, and only then is the second channel pulsed. The directed tasks do this by raising the line with a channel-0 start-of-frame and then pulsing a channel-3 end-of-frame. They also reach simultaneous events from two channels with the line low, and an event that lands in the same cycle as a clearing write. Flags that cannot be cleared are left set at the end of the run, and the bench proves them unclearable by masking them and watching `irq` fall.

// File: rtl/dic_pkg.sv
package dic_pkg;
   localparam int REG_AW = 3;
   localparam logic [REG_AW-1:0] A_MASKA = 3'd0;
   localparam logic [REG_AW-1:0] A_MASKB = 3'd1;
   localparam logic [REG_AW-1:0] A_FLAGA = 3'd2;
   localparam logic [REG_AW-1:0] A_FLAGB = 3'd3;
   localparam logic [REG_AW-1:0] A_EVID  = 3'd4;

   localparam logic [31:0] MASKA_KEEP = 32'h07FF_FFFF;
   localparam logic [31:0] MASKB_KEEP = 32'h3F3F_3F3F;
   localparam logic [31:0] FLAGA_W1C  = 32'h0000_0FFF;
   localparam logic [31:0] FLAGB_W1C  = 32'h003E_3F3F;

   // FLAGA bit positions
   localparam int FA_LAST = 0;
   localparam int FA_SOF  = 1;
   localparam int FA_BER  = 2;
   localparam int FA_BIAS = 3;
   localparam int FA_UR0  = 4;
   localparam int FA_UR1  = 5;
   localparam int FA_OUR  = 6;
   localparam int FA_QDIS = 7;
   localparam int FA_EOF  = 8;
   localparam int FA_BRN  = 9;
   localparam int FA_MORE = 10;
   localparam int FA_RDST = 11;
   localparam int FA_CMD  = 12;
   localparam int FA_NB   = 13;
   localparam int FA_CH_LO = 28;

   // MASKA bit positions
   localparam int MA_EN   = 0;
   localparam int MA_LAST = 3;
   localparam int MA_SOF  = 4;
   localparam int MA_UR0  = 5;
   localparam int MA_EOF  = 6;
   localparam int MA_QDIS = 11;
   localparam int MA_BRN  = 20;
   localparam int MA_OUR  = 21;
   localparam int MA_RDST = 23;
   localparam int MA_CMD  = 24;
   // MASKB bit for underrun 1
   localparam int MB_UR1  = 24;

   // FLAGB / MASKB offsets for auxiliary channel c
   localparam int FB_SOF_OFS = -1;
   localparam int FB_EOF_OFS = 7;
   localparam int FB_BRN_OFS = 15;
endpackage

// File: rtl/dic_level.sv
module dic_level
   import dic_pkg::*;
(
   input  logic [FA_NB-1:0] flaga,
   input  logic [31:0]      flagb,
   input  logic [31:0]      maska,
   input  logic [31:0]      maskb,
   output logic             level
);
   logic prim;

   always_comb begin
      prim = (flaga[FA_LAST] & ~maska[MA_LAST])
           | (flaga[FA_SOF]  & ~maska[MA_SOF])
           | (flaga[FA_UR0]  & ~maska[MA_UR0])
           | (flaga[FA_UR1]  & ~maskb[MB_UR1])
           | (flaga[FA_OUR]  & ~maska[MA_OUR])
           | (flaga[FA_QDIS] & ~maska[MA_QDIS])
           | (flaga[FA_EOF]  & ~maska[MA_EOF])
           | (flaga[FA_BRN]  & ~maska[MA_BRN])
           | (flaga[FA_RDST] & ~maska[MA_RDST])
           | (flaga[FA_CMD]  & ~maska[MA_CMD]);
      level = prim | (|(flagb & ~maskb));
   end
endmodule

// File: rtl/dic_route.sv
module dic_route
   import dic_pkg::*;
#(
   parameter int NCH  = 7,
   parameter int ID_W = 32
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              irq_now,
   input  logic [31:0]       maska,
   input  logic [31:0]       maskb,
   input  logic [NCH-1:0]    ev_sof,
   input  logic [NCH-1:0]    ev_eof,
   input  logic [NCH-1:0]    ev_brn,
   input  logic              ev_ber,
   input  logic [2:0]        ber_chan,
   input  logic              ev_rdst,
   input  logic [NCH*ID_W-1:0] frame_id,
   output logic              more_set,
   output logic [ID_W-1:0]   evid_q
);
   localparam int NEV = 3 * NCH + 1;
   localparam int CW  = $clog2(NCH);

   logic [NCH-1:0] sof_m, eof_m, brn_m;
   logic [NCH-1:0] hit;
   logic [NEV-1:0] live;
   logic           ber_ok;
   logic           any_live, many_live;
   logic [CW-1:0]  win;
   logic           load_id;

   for (genvar c = 0; c < NCH; c++) begin : g_mask
      if (c == 0) begin : g_prim
         assign sof_m[c] = maska[MA_SOF];
         assign eof_m[c] = maska[MA_EOF];
         assign brn_m[c] = maska[MA_BRN];
      end else begin : g_aux
         assign sof_m[c] = maskb[c + FB_SOF_OFS];
         assign eof_m[c] = maskb[c + FB_EOF_OFS];
         assign brn_m[c] = maskb[c + FB_BRN_OFS];
      end
      assign hit[c] = (ev_sof[c] & ~sof_m[c]) | (ev_eof[c] & ~eof_m[c])
                    | (ev_brn[c] & ~brn_m[c])
                    | (ber_ok & (32'(ber_chan) == c));
   end

   assign ber_ok = ev_ber && (32'(ber_chan) < NCH);
   assign live   = {ev_sof & ~sof_m, ev_eof & ~eof_m, ev_brn & ~brn_m, ber_ok};

   always_comb begin
      any_live  = |live;
      many_live = $countones(live) > 1;
      win = '0;
      for (int c = NCH - 1; c >= 0; c--)
         if (hit[c]) win = CW'(c);
      load_id  = !irq_now && any_live;
      more_set = irq_now ? (any_live | (ev_rdst & ~maska[MA_RDST])) : many_live;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         evid_q <= '0;
      else if (load_id)
         evid_q <= frame_id[win*ID_W +: ID_W];
   end

   // R5
   evid_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_now |=> $stable(evid_q));

   // R4
   evid_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_now && ev_sof[0] && !maska[MA_SOF]) |=> (evid_q == $past(frame_id[ID_W-1:0])));
endmodule

// File: rtl/dic_status.sv
module dic_status
   import dic_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic [FA_NB-1:0] seta,
   input  logic [FA_NB-1:0] clra,
   input  logic [31:0]      setb,
   input  logic [31:0]      clrb,
   input  logic             ch_load,
   input  logic [2:0]       ch_val,
   input  logic             ch_clr,
   output logic [FA_NB-1:0] flaga_q,
   output logic [31:0]      flagb_q,
   output logic [2:0]       berch_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flaga_q <= '0;
         flagb_q <= '0;
         berch_q <= '0;
      end else begin
         flaga_q <= (flaga_q & ~clra) | seta;
         flagb_q <= (flagb_q & ~clrb) | setb;
         if (ch_load)
            berch_q <= ch_val;
         else if (ch_clr)
            berch_q <= '0;
      end
   end

   // R7
   ber_rec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ch_load |=> (flaga_q[FA_BER] && berch_q == $past(ch_val)));

   // R12
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (|seta) |=> ((flaga_q & $past(seta)) == $past(seta)));
endmodule

// File: rtl/disp_irq_ctrl.sv
module disp_irq_ctrl
   import dic_pkg::*;
#(
   parameter int NCH  = 7,
   parameter int ID_W = 32
)(
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 wr_en,
   input  logic [2:0]           addr,
   input  logic [31:0]          wdata,
   output logic [31:0]          rdata,
   input  logic [NCH-1:0]       ev_sof,
   input  logic [NCH-1:0]       ev_eof,
   input  logic [NCH-1:0]       ev_brn,
   input  logic                 ev_ber,
   input  logic [2:0]           ber_chan,
   input  logic                 ev_last,
   input  logic                 ev_bias,
   input  logic                 ev_urun0,
   input  logic                 ev_urun1,
   input  logic                 ev_ourun,
   input  logic                 ev_rdst,
   input  logic                 ev_cmd,
   input  logic [NCH*ID_W-1:0]  frame_id,
   output logic                 irq
);
   if (NCH < 2 || NCH > 7) begin : g_bad_nch
      $error("disp_irq_ctrl: NCH must lie in 2..7");
   end
   if (ID_W < 1 || ID_W > 32) begin : g_bad_idw
      $error("disp_irq_ctrl: ID_W must lie in 1..32");
   end

   logic [31:0]      maska_q, maskb_q;
   logic [FA_NB-1:0] flaga_q, seta, clra;
   logic [31:0]      flagb_q, setb, clrb;
   logic [2:0]       berch_q;
   logic [ID_W-1:0]  evid_q;
   logic             more_set, qdis_set;
   logic             wr_ma, wr_mb, wr_fa, wr_fb;

   assign wr_ma = wr_en && addr == A_MASKA;
   assign wr_mb = wr_en && addr == A_MASKB;
   assign wr_fa = wr_en && addr == A_FLAGA;
   assign wr_fb = wr_en && addr == A_FLAGB;
   assign qdis_set = wr_ma && maska_q[MA_EN] && !wdata[MA_EN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         maska_q <= '0;
         maskb_q <= '0;
      end else begin
         if (wr_ma) maska_q <= wdata & MASKA_KEEP;
         if (wr_mb) maskb_q <= wdata & MASKB_KEEP;
      end
   end

   always_comb begin
      seta = '0;
      seta[FA_LAST] = ev_last;
      seta[FA_SOF]  = ev_sof[0];
      seta[FA_BER]  = ev_ber;
      seta[FA_BIAS] = ev_bias;
      seta[FA_UR0]  = ev_urun0;
      seta[FA_UR1]  = ev_urun1;
      seta[FA_OUR]  = ev_ourun;
      seta[FA_QDIS] = qdis_set;
      seta[FA_EOF]  = ev_eof[0];
      seta[FA_BRN]  = ev_brn[0];
      seta[FA_MORE] = more_set;
      seta[FA_RDST] = ev_rdst;
      seta[FA_CMD]  = ev_cmd;
      clra = wr_fa ? FA_NB'(wdata & FLAGA_W1C) : '0;
      clrb = wr_fb ? (wdata & FLAGB_W1C) : '0;
   end

   for (genvar c = 0; c < 32; c++) begin : g_setb
      if (c + 1 >= 1 && c + 1 < NCH) begin : g_s
         assign setb[c] = ev_sof[c + 1];
      end else if (c - FB_EOF_OFS >= 1 && c - FB_EOF_OFS < NCH) begin : g_e
         assign setb[c] = ev_eof[c - FB_EOF_OFS];
      end else if (c - FB_BRN_OFS >= 1 && c - FB_BRN_OFS < NCH) begin : g_b
         assign setb[c] = ev_brn[c - FB_BRN_OFS];
      end else begin : g_z
         assign setb[c] = 1'b0;
      end
   end

   dic_status u_status (
      .clk     (clk),
      .rst_n   (rst_n),
      .seta    (seta),
      .clra    (clra),
      .setb    (setb),
      .clrb    (clrb),
      .ch_load (ev_ber),
      .ch_val  (ber_chan),
      .ch_clr  (wr_fa && wdata[FA_BER]),
      .flaga_q (flaga_q),
      .flagb_q (flagb_q),
      .berch_q (berch_q)
   );

   dic_level u_level (
      .flaga (flaga_q),
      .flagb (flagb_q),
      .maska (maska_q),
      .maskb (maskb_q),
      .level (irq)
   );

   dic_route #(.NCH(NCH), .ID_W(ID_W)) u_route (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_now  (irq),
      .maska    (maska_q),
      .maskb    (maskb_q),
      .ev_sof   (ev_sof),
      .ev_eof   (ev_eof),
      .ev_brn   (ev_brn),
      .ev_ber   (ev_ber),
      .ber_chan (ber_chan),
      .ev_rdst  (ev_rdst),
      .frame_id (frame_id),
      .more_set (more_set),
      .evid_q   (evid_q)
   );

   always_comb begin
      case (addr)
         A_MASKA: rdata = maska_q;
         A_MASKB: rdata = maskb_q;
         A_FLAGA: rdata = {1'b0, berch_q, {(FA_CH_LO-FA_NB){1'b0}}, flaga_q};
         A_FLAGB: rdata = flagb_q;
         A_EVID:  rdata = 32'(evid_q);
         default: rdata = '0;
      endcase
   end

   // R10
   qdis_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == A_MASKA && maska_q[MA_EN] && !wdata[MA_EN]) |=> flaga_q[FA_QDIS]);

   // R2
   irq_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq |-> ((|flaga_q) || (|flagb_q)));

   // R1
   rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> !irq);
endmodule

// File: tb/disp_irq_ctrl_bench.sv
module disp_irq_ctrl_bench;
   localparam int NCH = 7;
   localparam int ID_W = 32;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic wr_en = 1'b0;
   logic [2:0] addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic [NCH-1:0] ev_sof = '0, ev_eof = '0, ev_brn = '0;
   logic ev_ber = 1'b0;
   logic [2:0] ber_chan = '0;
   logic ev_last = 0, ev_bias = 0, ev_urun0 = 0, ev_urun1 = 0, ev_ourun = 0, ev_rdst = 0, ev_cmd = 0;
   logic [NCH*ID_W-1:0] frame_id;
   logic irq;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #2 clk = ~clk;

   disp_irq_ctrl u_disp_irq_ctrl (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
      .ev_sof(ev_sof), .ev_eof(ev_eof), .ev_brn(ev_brn), .ev_ber(ev_ber), .ber_chan(ber_chan),
      .ev_last(ev_last), .ev_bias(ev_bias), .ev_urun0(ev_urun0), .ev_urun1(ev_urun1),
      .ev_ourun(ev_ourun), .ev_rdst(ev_rdst), .ev_cmd(ev_cmd), .frame_id(frame_id), .irq(irq)
   );

   task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic rd(input logic [2:0] a, output logic [31:0] v);
      addr = a;
      #1 v = rdata;
   endtask

   task automatic chk_reg(input string req, input logic [2:0] a, input logic [31:0] exp);
      logic [31:0] v;
      rd(a, v);
      chk(req, v, exp);
   endtask

   task automatic wr(input logic [2:0] a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1; addr = a; wdata = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   // misc order: {cmd, rdst, ourun, urun1, urun0, bias, last}
   task automatic pulse(input logic [NCH-1:0] s, input logic [NCH-1:0] e, input logic [NCH-1:0] b,
                        input logic ber, input logic [2:0] bch, input logic [6:0] misc);
      @(negedge clk);
      ev_sof = s; ev_eof = e; ev_brn = b; ev_ber = ber; ber_chan = bch;
      {ev_cmd, ev_rdst, ev_ourun, ev_urun1, ev_urun0, ev_bias, ev_last} = misc;
      @(negedge clk);
      ev_sof = '0; ev_eof = '0; ev_brn = '0; ev_ber = 0; ber_chan = '0;
      {ev_cmd, ev_rdst, ev_ourun, ev_urun1, ev_urun0, ev_bias, ev_last} = '0;
   endtask

   task automatic t_reset();
      for (int a = 0; a < 5; a++) chk_reg("R1 reg zero", 3'(a), 32'h0);
      chk("R1 irq low", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_ctrl();
      wr(0, 32'hFFFF_FFFF);
      chk_reg("R11 MASKA keep", 0, 32'h07FF_FFFF);
      wr(1, 32'hFFFF_FFFF);
      chk_reg("R11 MASKB keep", 1, 32'h3F3F_3F3F);
      wr(4, 32'hDEAD_BEEF);
      chk_reg("R11 EVID ignores write", 4, 32'h0);
      wr(1, 0);
      wr(0, 0);
      chk_reg("R10 quick disable flag", 2, 32'h80);
      chk("R2 qdis unmasked irq", {31'b0, irq}, 32'h1);
      wr(0, 32'h800);
      chk("R2 qdis masked irq", {31'b0, irq}, 32'h0);
      wr(2, 32'h80);
      wr(0, 0);
      chk_reg("R8 qdis cleared", 2, 32'h0);
   endtask

   task automatic t_more();
      pulse(7'h01, 0, 0, 0, 0, 0);
      chk_reg("R3 sof ch0 flag", 2, 32'h2);
      chk_reg("R4 evid load ch0", 4, 32'h1000);
      chk("R2 sof irq", {31'b0, irq}, 32'h1);
      pulse(0, 7'h08, 0, 0, 0, 0);
      chk_reg("R3 eof ch3 flagb", 3, 32'h400);
      chk_reg("R5 more bit set", 2, 32'h402);
      chk_reg("R5 evid held", 4, 32'h1000);
      wr(2, 32'hFFF);
      wr(3, 32'h3E3F3F);
      chk_reg("R8 flaga cleared", 2, 32'h0);
      chk_reg("R9 flagb cleared", 3, 32'h0);
      chk("R2 irq dropped", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_simul();
      pulse(7'h04, 0, 7'h20, 0, 0, 0);
      chk_reg("R6 lowest channel id", 4, 32'h1002);
      chk_reg("R6 more bit", 2, 32'h400);
      chk_reg("R3 flagb sof2 brn5", 3, 32'h0010_0002);
      wr(2, 32'hFFF);
      wr(3, 32'h3E3F3F);
   endtask

   task automatic t_masked();
      wr(1, 32'h8);
      pulse(7'h10, 0, 0, 0, 0, 0);
      chk_reg("R3 masked flag set", 3, 32'h8);
      chk("R4 masked no irq", {31'b0, irq}, 32'h0);
      chk_reg("R4 masked no more", 2, 32'h0);
      chk_reg("R4 masked evid kept", 4, 32'h1002);
      wr(3, 32'h8);
      wr(1, 0);
   endtask

   task automatic t_ber();
      pulse(0, 0, 0, 1, 3'd6, 0);
      chk_reg("R7 ber flag and chan", 2, 32'h6000_0004);
      chk_reg("R7 ber evid", 4, 32'h1006);
      chk("R2 ber no irq", {31'b0, irq}, 32'h0);
      wr(2, 32'h4);
      chk_reg("R8 ber clears chan", 2, 32'h0);
      pulse(0, 0, 0, 1, 3'd3, 0);
      chk_reg("R7 ber evid ch3", 4, 32'h1003);
      wr(2, 32'h800);
      chk_reg("R8 chan kept", 2, 32'h3000_0004);
      wr(2, 32'h4);
      chk_reg("R8 chan cleared", 2, 32'h0);
   endtask

   task automatic t_misc();
      pulse(0, 0, 0, 0, 0, 7'b0111111);
      chk_reg("R13 misc flags", 2, 32'h879);
      chk("R13 misc irq", {31'b0, irq}, 32'h1);
      chk_reg("R13 misc no evid", 4, 32'h1003);
      pulse(0, 0, 0, 0, 0, 7'b0100000);
      chk_reg("R13 rdst more", 2, 32'hC79);
      wr(2, 32'hFFF);
      chk_reg("R8 misc cleared", 2, 32'h0);
      wr(1, 32'h0100_0000);
      pulse(0, 0, 0, 0, 0, 7'b0001000);
      chk_reg("R13 urun1 flag", 2, 32'h20);
      chk("R2 urun1 masked by MASKB", {31'b0, irq}, 32'h0);
      wr(2, 32'h20);
      wr(1, 0);
   endtask

   task automatic t_setwins();
      @(negedge clk);
      wr_en = 1; addr = 2; wdata = 32'h100; ev_eof = 7'h01;
      @(negedge clk);
      wr_en = 0; ev_eof = '0;
      chk_reg("R12 set beats clear", 2, 32'h100);
      chk_reg("R4 eof ch0 evid", 4, 32'h1000);
      wr(2, 32'h100);
   endtask

   task automatic t_sticky();
      pulse(0, 0, 7'h02, 0, 0, 0);
      chk_reg("R3 brn ch1 bit16", 3, 32'h1_0000);
      chk_reg("R4 brn ch1 evid", 4, 32'h1001);
      wr(3, 32'hFFFF_FFFF);
      chk_reg("R9 bit16 survives", 3, 32'h1_0000);
      chk("R2 flagb irq", {31'b0, irq}, 32'h1);
      wr(1, 32'h1_0000);
      chk("R2 flagb masked", {31'b0, irq}, 32'h0);
      pulse(0, 0, 0, 0, 0, 7'b1000000);
      chk_reg("R13 cmd flag", 2, 32'h1000);
      chk("R2 cmd irq", {31'b0, irq}, 32'h1);
      wr(2, 32'hFFFF_FFFF);
      chk_reg("R8 cmd not clearable", 2, 32'h1000);
      wr(0, 32'h0100_0000);
      chk("R2 cmd masked", {31'b0, irq}, 32'h0);
   endtask

   initial begin
      for (int c = 0; c < NCH; c++) frame_id[c*ID_W +: ID_W] = 32'h1000 + c;
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_ctrl();
      t_more();
      t_simul();
      t_masked();
      t_ber();
      t_misc();
      t_setwins();
      t_sticky();
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule